// File: doc/BRIEF.md
# Multi-queue command pipe scheduler

This block holds a small number of command pipes. Each pipe owns a set of queue slots and issues command words from only one slot at a time. A slot carries three descriptor registers (ring base address, save-area address, doorbell value), a mapped flag, an activation request bit written by firmware, and a readable active status driven by hardware. Commands reach each slot on its own valid/ready pair. Accepted words leave the pipe one cycle later on an issue stream tagged with the slot number.

A pipe reselects its slot only at a packet boundary. A 2-bit mode register, one per pipe, chooses what triggers a switch: a switch marker in the command stream, the end of every packet, or a pulse on the pipe's external scheduler request input. The next slot is chosen round-robin among slots that are both mapped and active. Firmware preempts a slot by clearing its activation request. The packet in flight is allowed to finish, and the active status then reads low, which is the signal that the descriptor state may be saved. Firmware restores a slot by writing the descriptor registers while the status is low, and then setting the request bit last.

Top module: `hqp_sched`

## Requirements
- R1: In any cycle at most one queue of a pipe has cmd_ready high. Every issued word carries in iss_qid the number of the queue it was taken from.
- R2: A queue is served only when it is mapped (control bit 1) and its activation request (control bit 0) is set. A request written with the mapped bit clear leaves the status reading 0, and the queue's words are not issued.
- R3: In mode 0, a word with bit CMD_W-2 (switch marker) set ends the packet, and the pipe then moves to the next eligible queue. Without a switch marker the pipe stays on its queue, even while that queue is empty.
- R4: In mode 1, the pipe moves round-robin to the next eligible queue after every word with bit CMD_W-1 (end of packet) set. It stays on the same queue only when that queue is the only eligible one.
- R5: In mode 2, the switch marker has no effect. A one-cycle pulse on sched_req for the pipe makes it move to the next eligible queue at the next packet boundary.
- R6: After firmware clears a queue's activation request in the middle of a packet, the queue keeps its current packet, and its status (control bit 0) stays 1 until the end-of-packet word is accepted. The status reads 0 from the following cycle on.
- R7: Writes to the descriptor registers (address 0 = base, 1 = save area, 2 = doorbell) are ignored while the queue's status reads 1, and take effect while it reads 0. All three registers read back on fw_rdata.
- R8: A control write (address 3) with both the mapped and the request bits set makes the status read 1 from the next cycle. The queue then becomes eligible for issue.
- R9: pipe_idle is 1 for a pipe that has no eligible queue to serve. While it is 1, that pipe drives no cmd_ready.
- R10: After reset all pipes are idle and issue nothing, no queue is ready, and all control and descriptor registers read 0. The mode registers (address 4) read 0.
- R11: A word accepted on a cmd_valid/cmd_ready handshake appears on iss_data with iss_valid one cycle later, in acceptance order, with none lost or duplicated.
- R12: The pipes are independent. Configuration and traffic on one pipe produce no issue on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fw_we | input | 1 | Firmware register write strobe |
| fw_pipe | input | PW | Pipe selected for the register access |
| fw_queue | input | QW | Queue selected for the register access |
| fw_addr | input | 3 | Register address: 0 base, 1 save, 2 doorbell, 3 control, 4 mode |
| fw_wdata | input | DATA_W | Write data |
| fw_rdata | output | DATA_W | Combinational read data of the addressed register |
| sched_req | input | NUM_PIPES | External switch request, one bit per pipe |
| cmd_valid | input | NUM_PIPES*NUM_Q | Command word valid per queue (pipe-major) |
| cmd_data | input | NUM_PIPES*NUM_Q*CMD_W | Command words per queue; bit CMD_W-1 end of packet, bit CMD_W-2 switch marker |
| cmd_ready | output | NUM_PIPES*NUM_Q | Command word taken per queue |
| iss_valid | output | NUM_PIPES | Issue word valid per pipe |
| iss_data | output | NUM_PIPES*CMD_W | Issued command word per pipe |
| iss_qid | output | NUM_PIPES*QW | Source queue of the issued word per pipe |
| pipe_idle | output | NUM_PIPES | Pipe has no queue to serve |

## Verification
A wrong current-queue register shows up within one cycle as a word issued with the wrong iss_qid, or as cmd_ready on a queue that is not eligible. A lost switch trigger shows up as a queue order that differs from the round-robin sequence expected for the selected mode. A status bit that falls too early is visible on fw_rdata at once, and a descriptor write that lands while the status is 1 reads back wrong on the following access. A stuck packet state freezes the issue stream and leaves pipe_idle low after the last active queue has drained.

// File: rtl/hqp_pkg.sv
package hqp_pkg;
  typedef enum logic [1:0] {
    SWM_CMD = 2'd0,
    SWM_PKT = 2'd1,
    SWM_EXT = 2'd2,
    SWM_RSV = 2'd3
  } sw_mode_e;

  localparam logic [2:0] RA_BASE  = 3'd0;
  localparam logic [2:0] RA_SAVE  = 3'd1;
  localparam logic [2:0] RA_DBELL = 3'd2;
  localparam logic [2:0] RA_CTRL  = 3'd3;
  localparam logic [2:0] RA_MODE  = 3'd4;

  localparam int CTRL_ACT_BIT = 0;
  localparam int CTRL_MAP_BIT = 1;
endpackage

// File: rtl/hqp_slot.sv
module hqp_slot
  import hqp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hold_i,
  output logic [DATA_W-1:0] rdata,
  output logic              elig_o
);
  logic [DATA_W-1:0] base_q, base_d, save_q, save_d, dbell_q, dbell_d;
  logic              mapped_q, mapped_d, req_q, req_d, sts_q, sts_d;
  logic              desc_ok;

  assign desc_ok = wr_en && !sts_q;

  always_comb begin
    base_d   = base_q;
    save_d   = save_q;
    dbell_d  = dbell_q;
    mapped_d = mapped_q;
    req_d    = req_q;
    if (desc_ok && addr == RA_BASE)  base_d  = wdata;
    if (desc_ok && addr == RA_SAVE)  save_d  = wdata;
    if (desc_ok && addr == RA_DBELL) dbell_d = wdata;
    if (wr_en && addr == RA_CTRL) begin
      mapped_d = wdata[CTRL_MAP_BIT];
      req_d    = wdata[CTRL_MAP_BIT] && wdata[CTRL_ACT_BIT];
    end
    sts_d = req_d || (sts_q && hold_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      save_q   <= '0;
      dbell_q  <= '0;
      mapped_q <= 1'b0;
      req_q    <= 1'b0;
      sts_q    <= 1'b0;
    end else begin
      if (desc_ok) begin
        base_q  <= base_d;
        save_q  <= save_d;
        dbell_q <= dbell_d;
      end
      mapped_q <= mapped_d;
      req_q    <= req_d;
      sts_q    <= sts_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_BASE:  rdata = base_q;
      RA_SAVE:  rdata = save_q;
      RA_DBELL: rdata = dbell_q;
      RA_CTRL: begin
        rdata[CTRL_MAP_BIT] = mapped_q;
        rdata[CTRL_ACT_BIT] = sts_q;
      end
      default:  rdata = '0;
    endcase
  end

  assign elig_o = sts_q && req_q;

  assert_desc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q |=> $stable({base_q, save_q, dbell_q}));
  assert_rise_needs_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> mapped_q);
  assert_fall_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q) |-> $past(!hold_i));
endmodule

// File: rtl/hqp_rr.sv
module hqp_rr #(
  parameter int NQ = 2,
  parameter int QW = 1
) (
  input  logic [NQ-1:0] req,
  input  logic [QW-1:0] last,
  output logic          found,
  output logic [QW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int off = NQ; off >= 1; off--) begin
      if (req[(int'(last) + off) % NQ]) begin
        found = 1'b1;
        pick  = QW'((int'(last) + off) % NQ);
      end
    end
  end
endmodule

// File: rtl/hqp_pipe.sv
module hqp_pipe
  import hqp_pkg::*;
#(
  parameter int NQ     = 2,
  parameter int CMD_W  = 16,
  parameter int DATA_W = 32,
  parameter int QW     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_we,
  input  logic [QW-1:0]     fw_queue,
  input  logic [2:0]        fw_addr,
  input  logic [DATA_W-1:0] fw_wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sched_req,
  input  logic [NQ-1:0]     cmd_valid,
  input  logic [NQ*CMD_W-1:0] cmd_data,
  output logic [NQ-1:0]     cmd_ready,
  output logic              iss_valid,
  output logic [CMD_W-1:0]  iss_data,
  output logic [QW-1:0]     iss_qid,
  output logic              idle
);
  localparam int EOP_BIT = CMD_W - 1;
  localparam int SW_BIT  = CMD_W - 2;

  logic [QW-1:0]     cur_q, cur_d, rr_pick;
  logic              cur_valid_q, cur_valid_d, in_pkt_q, in_pkt_d;
  logic              sw_pend_q, sw_pend_d, rr_found;
  sw_mode_e          mode_q, mode_d;
  logic [NQ-1:0]     elig;
  logic [DATA_W-1:0] slot_rd [NQ];
  logic [CMD_W-1:0]  cur_word;
  logic              need_resel, rdy_any, accept, boundary, mode_we;

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    hqp_slot #(.DATA_W(DATA_W)) slot_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fw_we && fw_queue == QW'(g) && fw_addr != RA_MODE),
      .addr(fw_addr), .wdata(fw_wdata),
      .hold_i(cur_valid_q && cur_q == QW'(g) && in_pkt_d),
      .rdata(slot_rd[g]), .elig_o(elig[g])
    );
    assign cmd_ready[g] = rdy_any && cur_q == QW'(g);
  end

  hqp_rr #(.NQ(NQ), .QW(QW)) rr_i (
    .req(elig), .last(cur_q), .found(rr_found), .pick(rr_pick)
  );

  assign cur_word   = cmd_data[int'(cur_q)*CMD_W +: CMD_W];
  assign need_resel = !in_pkt_q && (sw_pend_q || !cur_valid_q || !elig[cur_q]);
  assign rdy_any    = cur_valid_q && !need_resel;
  assign accept     = rdy_any && cmd_valid[cur_q];
  assign boundary   = cur_word[EOP_BIT] || (cur_word[SW_BIT] && mode_q == SWM_CMD);
  assign mode_we    = fw_we && fw_addr == RA_MODE;

  always_comb begin
    cur_d       = cur_q;
    cur_valid_d = cur_valid_q;
    in_pkt_d    = in_pkt_q;
    sw_pend_d   = sw_pend_q;
    mode_d      = mode_q;
    if (need_resel) begin
      cur_valid_d = rr_found;
      if (rr_found) cur_d = rr_pick;
      sw_pend_d = 1'b0;
    end
    if (accept) begin
      in_pkt_d = !boundary;
      if (mode_q == SWM_CMD && cur_word[SW_BIT]) sw_pend_d = 1'b1;
      if (mode_q == SWM_PKT && boundary) sw_pend_d = 1'b1;
    end
    if ((mode_q == SWM_EXT || mode_q == SWM_RSV) && sched_req) sw_pend_d = 1'b1;
    if (mode_we) mode_d = sw_mode_e'(fw_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= QW'(NQ - 1);
      cur_valid_q <= 1'b0;
      in_pkt_q    <= 1'b0;
      sw_pend_q   <= 1'b0;
      mode_q      <= SWM_CMD;
      iss_valid   <= 1'b0;
      iss_data    <= '0;
      iss_qid     <= '0;
    end else begin
      cur_q       <= cur_d;
      cur_valid_q <= cur_valid_d;
      in_pkt_q    <= in_pkt_d;
      sw_pend_q   <= sw_pend_d;
      mode_q      <= mode_d;
      iss_valid   <= accept;
      if (accept) begin
        iss_data <= cur_word;
        iss_qid  <= cur_q;
      end
    end
  end

  assign idle = !cur_valid_q;

  always_comb begin
    rdata = '0;
    if (fw_addr == RA_MODE) rdata[1:0] = mode_q;
    else if (int'(fw_queue) < NQ) rdata = slot_rd[fw_queue];
  end

  assert_one_queue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_ready));
  assert_ready_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_ready) |-> (in_pkt_q || elig[cur_q]));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> cmd_ready == '0);
  assert_issue_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cmd_ready & cmd_valid)) |=> (iss_valid && iss_qid == $past(cur_q)));
endmodule

// File: rtl/hqp_sched.sv
module hqp_sched #(
  parameter int NUM_PIPES = 2,
  parameter int NUM_Q     = 2,
  parameter int CMD_W     = 16,
  parameter int DATA_W    = 32,
  localparam int PW = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fw_we,
  input  logic [PW-1:0]                fw_pipe,
  input  logic [QW-1:0]                fw_queue,
  input  logic [2:0]                   fw_addr,
  input  logic [DATA_W-1:0]            fw_wdata,
  output logic [DATA_W-1:0]            fw_rdata,
  input  logic [NUM_PIPES-1:0]         sched_req,
  input  logic [NUM_PIPES*NUM_Q-1:0]   cmd_valid,
  input  logic [NUM_PIPES*NUM_Q*CMD_W-1:0] cmd_data,
  output logic [NUM_PIPES*NUM_Q-1:0]   cmd_ready,
  output logic [NUM_PIPES-1:0]         iss_valid,
  output logic [NUM_PIPES*CMD_W-1:0]   iss_data,
  output logic [NUM_PIPES*QW-1:0]      iss_qid,
  output logic [NUM_PIPES-1:0]         pipe_idle
);
  logic              rst_meta_q, rst_sync_n;
  logic [DATA_W-1:0] pipe_rd [NUM_PIPES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    hqp_pipe #(.NQ(NUM_Q), .CMD_W(CMD_W), .DATA_W(DATA_W), .QW(QW)) pipe_i (
      .clk(clk), .rst_n(rst_sync_n),
      .fw_we(fw_we && fw_pipe == PW'(p)),
      .fw_queue(fw_queue), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
      .rdata(pipe_rd[p]), .sched_req(sched_req[p]),
      .cmd_valid(cmd_valid[p*NUM_Q +: NUM_Q]),
      .cmd_data(cmd_data[p*NUM_Q*CMD_W +: NUM_Q*CMD_W]),
      .cmd_ready(cmd_ready[p*NUM_Q +: NUM_Q]),
      .iss_valid(iss_valid[p]),
      .iss_data(iss_data[p*CMD_W +: CMD_W]),
      .iss_qid(iss_qid[p*QW +: QW]),
      .idle(pipe_idle[p])
    );
  end

  assign fw_rdata = (int'(fw_pipe) < NUM_PIPES) ? pipe_rd[fw_pipe] : '0;
endmodule

// File: tb/hqp_sched_tb.sv
module hqp_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2, NQ = 2, CW = 16, DW = 32, NK = NP * NQ;
  localparam logic [15:0] EOP = 16'h8000, SWM = 16'h4000;
  localparam int WD_LIMIT = 50000;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            fw_we = 1'b0;
  logic [0:0]      fw_pipe = '0, fw_queue = '0;
  logic [2:0]      fw_addr = '0;
  logic [DW-1:0]   fw_wdata = '0, fw_rdata;
  logic [NP-1:0]   sched_req = '0;
  logic [NK-1:0]   cmd_valid = '0, cmd_ready;
  logic [NK*CW-1:0] cmd_data = '0;
  logic [NP-1:0]   iss_valid, pipe_idle;
  logic [NP*CW-1:0] iss_data;
  logic [NP-1:0]   iss_qid;

  int checks = 0, errors = 0, cyc = 0, multi_rdy = 0;
  logic [15:0] src [NK][$];
  logic [31:0] sb [NP][$];
  int          logq [NP][$];
  logic [NK-1:0] take = '0;

  hqp_sched #(.NUM_PIPES(NP), .NUM_Q(NQ), .CMD_W(CW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fw_we(fw_we), .fw_pipe(fw_pipe), .fw_queue(fw_queue),
    .fw_addr(fw_addr), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata), .sched_req(sched_req),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .iss_valid(iss_valid), .iss_data(iss_data), .iss_qid(iss_qid), .pipe_idle(pipe_idle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard engine: monitor, then source update, then expectation push.
  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (iss_valid[p]) begin
        if (sb[p].size() == 0) chk("R11 unexpected issue", int'(iss_data[p*CW +: CW]), -1);
        else begin
          logic [31:0] e;
          e = sb[p].pop_front();
          chk("R11/R1 issue word+qid", int'({15'd0, iss_qid[p], iss_data[p*CW +: CW]}), int'(e));
        end
        logq[p].push_back(int'(iss_qid[p]));
      end
    end
    for (int k = 0; k < NK; k++) if (take[k]) void'(src[k].pop_front());
    for (int k = 0; k < NK; k++) begin
      cmd_valid[k] = src[k].size() > 0;
      cmd_data[k*CW +: CW] = (src[k].size() > 0) ? src[k][0] : 16'h0;
    end
    #1;
    for (int k = 0; k < NK; k++) begin
      take[k] = cmd_valid[k] && cmd_ready[k];
      if (take[k]) sb[k/NQ].push_back({15'd0, 1'(k % NQ), cmd_data[k*CW +: CW]});
    end
    for (int p = 0; p < NP; p++)
      if ($countones(cmd_ready[p*NQ +: NQ]) > 1) multi_rdy++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      chk("watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic fw_wr(int p, int q, int a, int d);
    @(posedge clk); #2;
    fw_we = 1'b1; fw_pipe = 1'(p); fw_queue = 1'(q); fw_addr = 3'(a); fw_wdata = DW'(d);
    @(posedge clk); #2;
    fw_we = 1'b0;
  endtask

  task automatic fw_rd(int p, int q, int a, output int v);
    fw_pipe = 1'(p); fw_queue = 1'(q); fw_addr = 3'(a);
    #1;
    v = int'(fw_rdata);
  endtask

  function automatic int qcode(int p);
    int c = 0;
    while (logq[p].size() > 0) c = c * 10 + logq[p].pop_front() + 1;
    return c;
  endfunction

  initial begin
    int v;
    tick(3);
    @(negedge clk); rst_n = 1'b1;
    tick(4);
    // R10: reset state
    chk("R10 idle", int'(pipe_idle), 3);
    chk("R10 iss_valid", int'(iss_valid), 0);
    chk("R10 cmd_ready", int'(cmd_ready), 0);
    fw_rd(0, 0, 3, v); chk("R10 ctrl", v, 0);
    fw_rd(1, 1, 0, v); chk("R10 base", v, 0);
    fw_rd(0, 0, 4, v); chk("R10 mode", v, 0);

    // R7: descriptor write while status is low
    fw_wr(0, 0, 0, 32'h1000);
    fw_wr(0, 0, 2, 32'h77);
    fw_rd(0, 0, 0, v); chk("R7 base accepted", v, 32'h1000);
    fw_rd(0, 0, 2, v); chk("R7 doorbell accepted", v, 32'h77);

    // R3: stream-switch mode (0)
    src[0].push_back(16'h0001); src[0].push_back(EOP | 16'h02); src[0].push_back(EOP | 16'h03);
    src[1].push_back(EOP | 16'h04);
    fw_wr(0, 0, 3, 3);
    fw_rd(0, 0, 3, v); chk("R8 status high after activate", v, 3);
    fw_wr(0, 1, 3, 3);
    tick(20);
    chk("R3 stays on q0 without marker", qcode(0), 111);
    chk("R9 busy pipe not idle", int'(pipe_idle[0]), 0);
    src[0].push_back(SWM | 16'h05);
    tick(20);
    chk("R3 marker moves to q1", qcode(0), 12);

    // R4: per-packet mode (1)
    fw_wr(0, 0, 4, 1);
    fw_rd(0, 0, 4, v); chk("R4 mode readback", v, 1);
    src[0].push_back(16'h0006); src[0].push_back(EOP | 16'h07);
    src[1].push_back(EOP | 16'h08); src[1].push_back(EOP | 16'h09);
    tick(30);
    chk("R4 round robin per packet", qcode(0), 2112);

    // R5: external request mode (2)
    fw_wr(0, 0, 4, 2);
    src[0].push_back(SWM | EOP | 16'h0A); src[0].push_back(EOP | 16'h0B);
    src[1].push_back(EOP | 16'h0C);
    tick(20);
    chk("R5 marker ignored", qcode(0), 11);
    @(posedge clk); #2; sched_req = 2'b01;
    @(posedge clk); #2; sched_req = 2'b00;
    tick(10);
    chk("R5 request switches", qcode(0), 2);

    // R6/R7: preemption on pipe 1
    fw_wr(1, 0, 0, 32'h2222);
    fw_wr(1, 0, 3, 3);
    src[2].push_back(16'h000D);
    tick(10);
    chk("R6 first word issued", qcode(1), 1);
    fw_wr(1, 0, 3, 2);
    fw_rd(1, 0, 3, v); chk("R6 status held mid packet", v, 3);
    tick(5);
    fw_rd(1, 0, 3, v); chk("R6 status still held", v, 3);
    fw_wr(1, 0, 0, 32'hBEEF);
    fw_rd(1, 0, 0, v); chk("R7 write ignored while active", v, 32'h2222);
    src[2].push_back(EOP | 16'h0E);
    tick(6);
    chk("R6 packet finished", qcode(1), 1);
    fw_rd(1, 0, 3, v); chk("R6 status low after boundary", v, 2);
    chk("R9 idle after drain", int'(pipe_idle[1]), 1);
    fw_wr(1, 0, 0, 32'hBEEF);
    fw_rd(1, 0, 0, v); chk("R7 write accepted when inactive", v, 32'hBEEF);

    // R2: request without mapped bit
    src[3].push_back(EOP | 16'h0F);
    fw_wr(1, 1, 3, 1);
    tick(10);
    fw_rd(1, 1, 3, v); chk("R2 unmapped status low", v, 0);
    chk("R2 unmapped not issued", qcode(1), 0);
    chk("R2/R9 still idle", int'(pipe_idle[1]), 1);
    fw_wr(1, 1, 3, 3);
    tick(10);
    chk("R2 mapped queue issued", qcode(1), 2);

    // R12, R1, R11 closing checks
    chk("R12 pipe0 untouched by pipe1", qcode(0), 0);
    chk("R1 single ready per pipe", multi_rdy, 0);
    chk("R11 scoreboard drained", sb[0].size() + sb[1].size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule